// File: doc/BRIEF.md
# Two-level carry-lookahead adder

This block adds two unsigned or two's-complement operands plus an incoming carry, purely combinationally. Operands are split into 4-bit groups. Each group forms its internal carries in parallel from bit-level generate and propagate terms. A second lookahead stage forms every carry between groups directly from the group generate and propagate terms and the external carry. Because no carry passes serially from group to group, the logic depth grows with the logarithm of the width and not with the width itself.

The block returns the sum, the carry out of the top bit and a signed overflow flag. It also drives the generate and propagate terms of the whole operand width, so that an outer lookahead stage can combine several instances into a wider adder without a serial carry path.

Top module: `hier_cla_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + carry_i` for every operand value and either carry-in.
- R2: The carry entering each 4-bit group matches the carry that a serial ripple would deliver at that bit position, including a carry that starts at the carry-in and travels across every group (for example `a_i` all ones, `b_i` zero, `carry_i` 1 gives a zero sum).
- R3: `carry_o` is 1 exactly when `a_i + b_i + carry_i` is at least 2^WIDTH, so it flags unsigned overflow.
- R4: `ovf_o` is 1 exactly when the carry into the top bit differs from the carry out of it. This is the same as both operands having the same top bit while `sum_o` has the other top bit.
- R5: `blk_gen_o` is 1 exactly when `a_i + b_i` alone is at least 2^WIDTH. When it is 1, `carry_o` is 1 whatever the value of `carry_i`.
- R6: `blk_prop_o` is 1 exactly when `a_i ^ b_i` is all ones. When it is 1, `carry_o` equals `carry_i` and `blk_gen_o` is 0.
- R7: With WIDTH set to another multiple of 4 (8 is checked), the behaviour of R1, R3 and R4 holds at that width. A WIDTH that is not a positive multiple of 4 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum, modulo 2^WIDTH |
| carry_o | output | 1 | Carry out of the top bit (unsigned overflow) |
| ovf_o | output | 1 | Signed overflow |
| blk_gen_o | output | 1 | Generate term of the whole width |
| blk_prop_o | output | 1 | Propagate term of the whole width |

## Verification
The hardest case to reach is a carry that must cross every group boundary. This needs every bit of the operands to propagate, and random operands at full width almost never produce it. An 8-bit instance is therefore driven with every operand pair and both carry-in values, which covers all propagate runs at that width. The 16-bit instance gets directed vectors with full-length and mid-length propagate chains, plus random operands from a fixed seed.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Fixed size of one lookahead group in bits.
    localparam int unsigned GRP_BITS = 4;

    // Generate/propagate pair of one group.
    typedef struct packed {
        logic gen;
        logic prop;
    } grp_pg_t;

endpackage : cla_pkg

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o
);

    // One generate/propagate cell per operand bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign gen_o[i]  = a_i[i] & b_i[i];
        assign prop_o[i] = a_i[i] ^ b_i[i];
    end

endmodule : cla_bit_pg

// File: rtl/cla_group4.sv
module cla_group4
    import cla_pkg::*;
(
    input  logic [GRP_BITS-1:0] gen_i,
    input  logic [GRP_BITS-1:0] prop_i,
    input  logic                cin_i,
    output logic [GRP_BITS-1:0] carry_o,   // carry into each bit of the group
    output grp_pg_t             pg_o
);

    logic [GRP_BITS-1:0] carry_d;
    grp_pg_t             pg_d;

    // Every carry is a flat sum of products: no term depends on another carry.
    always_comb begin
        carry_d[0] = cin_i;
        carry_d[1] = gen_i[0]
                   | (prop_i[0] & cin_i);
        carry_d[2] = gen_i[1]
                   | (prop_i[1] & gen_i[0])
                   | (prop_i[1] & prop_i[0] & cin_i);
        carry_d[3] = gen_i[2]
                   | (prop_i[2] & gen_i[1])
                   | (prop_i[2] & prop_i[1] & gen_i[0])
                   | (prop_i[2] & prop_i[1] & prop_i[0] & cin_i);

        pg_d.gen  = gen_i[3]
                  | (prop_i[3] & gen_i[2])
                  | (prop_i[3] & prop_i[2] & gen_i[1])
                  | (prop_i[3] & prop_i[2] & prop_i[1] & gen_i[0]);
        pg_d.prop = &prop_i;
    end

    assign carry_o = carry_d;
    assign pg_o    = pg_d;

    // A group whose every bit propagates cannot also generate.
    always_comb begin : chk_grp
        if (!$isunknown({pg_o.gen, pg_o.prop}))
            AST_GRP_EXCLUSIVE: assert (!(pg_o.gen && pg_o.prop)) else $error("group gen and prop both set"); // R6
    end

endmodule : cla_group4

// File: rtl/cla_lookahead.sv
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int unsigned NGRP = 4
) (
    input  grp_pg_t [NGRP-1:0] pg_i,
    input  logic               cin_i,
    output logic [NGRP:0]      carry_o,   // carry into each group; top entry is carry out
    output logic               blk_gen_o,
    output logic               blk_prop_o
);

    logic [NGRP:0] carry_d;
    logic          gen_d;
    logic          prop_d;

    // Carry into group k: OR over lower groups j of G[j] gated by every P above j,
    // plus the external carry gated by all lower P. Same form as the bit level.
    always_comb begin
        carry_d    = '0;
        carry_d[0] = cin_i;
        for (int k = 1; k <= NGRP; k++) begin
            logic acc;
            logic term;
            logic pall;
            acc = 1'b0;
            for (int j = 0; j < k; j++) begin
                term = pg_i[j].gen;
                for (int m = j + 1; m < k; m++) begin
                    term = term & pg_i[m].prop;
                end
                acc = acc | term;
            end
            pall = 1'b1;
            for (int m = 0; m < k; m++) begin
                pall = pall & pg_i[m].prop;
            end
            carry_d[k] = acc | (pall & cin_i);
        end

        gen_d = 1'b0;
        for (int j = 0; j < NGRP; j++) begin
            logic term;
            term = pg_i[j].gen;
            for (int m = j + 1; m < NGRP; m++) begin
                term = term & pg_i[m].prop;
            end
            gen_d = gen_d | term;
        end

        prop_d = 1'b1;
        for (int m = 0; m < NGRP; m++) begin
            prop_d = prop_d & pg_i[m].prop;
        end
    end

    assign carry_o    = carry_d;
    assign blk_gen_o  = gen_d;
    assign blk_prop_o = prop_d;

endmodule : cla_lookahead

// File: rtl/hier_cla_adder.sv
module hier_cla_adder
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o,
    output logic             blk_gen_o,
    output logic             blk_prop_o
);

    localparam int unsigned NGRP = WIDTH / GRP_BITS;

    if ((WIDTH % GRP_BITS) != 0 || WIDTH < GRP_BITS) begin : g_bad_width
        $error("hier_cla_adder: WIDTH must be a positive multiple of 4");
    end

    logic [WIDTH-1:0]   bit_gen;
    logic [WIDTH-1:0]   bit_prop;
    logic [WIDTH-1:0]   bit_carry;
    grp_pg_t [NGRP-1:0] grp_pg;
    logic [NGRP:0]      grp_carry;

    cla_bit_pg #(
        .WIDTH (WIDTH)
    ) bit_pg_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .gen_o  (bit_gen),
        .prop_o (bit_prop)
    );

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        cla_group4 grp_i (
            .gen_i   (bit_gen [k*GRP_BITS +: GRP_BITS]),
            .prop_i  (bit_prop[k*GRP_BITS +: GRP_BITS]),
            .cin_i   (grp_carry[k]),
            .carry_o (bit_carry[k*GRP_BITS +: GRP_BITS]),
            .pg_o    (grp_pg[k])
        );

        // The lookahead carry out of group k equals a one-step ripple from its top bit.
        always_comb begin : chk_boundary
            if (!$isunknown({grp_carry[k+1], bit_gen[k*GRP_BITS+3],
                             bit_prop[k*GRP_BITS+3], bit_carry[k*GRP_BITS+3]}))
                AST_GRP_CARRY_MATCH: assert (grp_carry[k+1] ==
                    (bit_gen[k*GRP_BITS+3] | (bit_prop[k*GRP_BITS+3] & bit_carry[k*GRP_BITS+3])))
                    else $error("group carry disagrees with ripple"); // R2
        end
    end

    cla_lookahead #(
        .NGRP (NGRP)
    ) lah_i (
        .pg_i       (grp_pg),
        .cin_i      (carry_i),
        .carry_o    (grp_carry),
        .blk_gen_o  (blk_gen_o),
        .blk_prop_o (blk_prop_o)
    );

    assign sum_o   = bit_prop ^ bit_carry;
    assign carry_o = grp_carry[NGRP];
    assign ovf_o   = bit_carry[WIDTH-1] ^ grp_carry[NGRP];

    always_comb begin : chk_top
        if (!$isunknown({a_i, b_i, carry_i, sum_o, carry_o, ovf_o, blk_gen_o, blk_prop_o})) begin
            AST_SUM_EXACT: assert ({carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i}))
                else $error("sum mismatch"); // R1
            AST_SIGNED_OVF: assert (ovf_o == ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1])))
                else $error("signed overflow mismatch"); // R4
            AST_GEN_FORCES_CARRY: assert (!blk_gen_o || carry_o)
                else $error("generate without carry out"); // R5
            AST_PROP_PASSES_CIN: assert (blk_prop_o == (&(a_i ^ b_i)))
                else $error("propagate mismatch"); // R6
        end
    end

endmodule : hier_cla_adder

// File: tb/hier_cla_adder_tb.sv
module hier_cla_adder_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    int cycles   = 0;

    logic [15:0] a16, b16;
    logic        c16;
    logic [15:0] s16;
    logic        co16, ov16, g16, p16;

    logic [7:0]  a8, b8;
    logic        c8;
    logic [7:0]  s8;
    logic        co8, ov8, g8, p8;

    hier_cla_adder #(.WIDTH(16)) dut_i (
        .a_i(a16), .b_i(b16), .carry_i(c16), .sum_o(s16), .carry_o(co16),
        .ovf_o(ov16), .blk_gen_o(g16), .blk_prop_o(p16)
    );

    hier_cla_adder #(.WIDTH(8)) dut_w8_i (
        .a_i(a8), .b_i(b8), .carry_i(c8), .sum_o(s8), .carry_o(co8),
        .ovf_o(ov8), .blk_gen_o(g8), .blk_prop_o(p8)
    );

    task automatic chk(string tag, logic [16:0] act, logic [16:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (a=%0h b=%0h)", tag, act, exp, a16, b16);
        end
    endtask

    // Reference values for a w-bit add (w <= 16).
    function automatic logic [16:0] ref_full(int w, logic [15:0] a, logic [15:0] b, logic c);
        logic [16:0] m;
        m = (17'd1 << w) - 17'd1;
        return (({1'b0, a} & m) + ({1'b0, b} & m) + {16'd0, c});
    endfunction

    function automatic logic ref_ovf(int w, logic [15:0] a, logic [15:0] b, logic c);
        logic [16:0] f;
        f = ref_full(w, a, b, c);
        return (a[w-1] == b[w-1]) && (f[w-1] != a[w-1]);
    endfunction

    task automatic check16(string sfx);
        logic [16:0] f;
        logic [16:0] g;
        f = ref_full(16, a16, b16, c16);
        g = ref_full(16, a16, b16, 1'b0);
        chk({"R1 ", sfx}, {1'b0, s16}, {1'b0, f[15:0]});
        chk({"R3 ", sfx}, {16'd0, co16}, {16'd0, f[16]});
        chk({"R4 ", sfx}, {16'd0, ov16}, {16'd0, ref_ovf(16, a16, b16, c16)});
        chk({"R5 ", sfx}, {16'd0, g16}, {16'd0, g[16]});
        chk({"R6 ", sfx}, {16'd0, p16}, {16'd0, ((a16 ^ b16) == 16'hFFFF)});
    endtask

    task automatic drive16(logic [15:0] a, logic [15:0] b, logic c, string sfx);
        a16 = a; b16 = b; c16 = c;
        #1;
        check16(sfx);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [16:0] f8;
        seed = 32'd1234;
        void'($urandom(seed));
        a16 = '0; b16 = '0; c16 = 1'b0;
        a8 = '0; b8 = '0; c8 = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Quiet state: all-zero inputs give all-zero outputs.
        #1;
        chk("R1 zero", {1'b0, s16}, 17'd0);
        chk("R6 zero", {16'd0, p16}, 17'd0);
        chk("R5 zero", {16'd0, g16}, 17'd0);

        // Carry travelling across every group boundary.
        drive16(16'hFFFF, 16'h0000, 1'b1, "R2 full chain");
        chk("R2 full chain sum", {1'b0, s16}, 17'd0);
        chk("R6 chain cout=cin", {16'd0, co16}, 17'd1);
        drive16(16'hFFFF, 16'h0000, 1'b0, "R2 chain no cin");
        drive16(16'h00FF, 16'h0001, 1'b0, "R2 mid chain");
        chk("R2 mid chain sum", {1'b0, s16}, 17'h0100);
        drive16(16'h0FFF, 16'h0000, 1'b1, "R2 three groups");
        // Signed overflow corners.
        drive16(16'h7FFF, 16'h0001, 1'b0, "R4 pos wrap");
        chk("R4 pos wrap flag", {16'd0, ov16}, 17'd1);
        drive16(16'h8000, 16'h8000, 1'b0, "R4 neg wrap");
        chk("R5 neg wrap gen", {16'd0, g16}, 17'd1);
        drive16(16'h8000, 16'h7FFF, 1'b1, "R4 mixed signs");
        // Propagate patterns.
        drive16(16'h5555, 16'hAAAA, 1'b0, "R6 alt bits");
        drive16(16'h5555, 16'hAAAA, 1'b1, "R6 alt bits cin");
        drive16(16'hFFFF, 16'hFFFF, 1'b1, "R5 max");

        // Random full-width operands.
        for (int i = 0; i < 4000; i++) begin
            drive16(16'($urandom), 16'($urandom), 1'($urandom), "rand");
        end

        // Exhaustive at 8 bits.
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                for (int c = 0; c < 2; c++) begin
                    a8 = 8'(x); b8 = 8'(y); c8 = 1'(c);
                    #1;
                    f8 = ref_full(8, {8'd0, a8}, {8'd0, b8}, c8);
                    chk("R7,R1 w8 sum", {9'd0, s8}, {9'd0, f8[7:0]});
                    chk("R7,R3 w8 cout", {16'd0, co8}, {16'd0, f8[8]});
                    chk("R7,R4 w8 ovf", {16'd0, ov8}, {16'd0, ref_ovf(8, {8'd0, a8}, {8'd0, b8}, c8)});
                end
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule : hier_cla_adder_tb_top